// File: doc/BRIEF.md
# ALU with Status Flag Register

This block is the 8-bit arithmetic and logic stage of a small processor core together with the status byte it maintains. Each operation takes the working register and a second value. The second value is either a file-register value or an immediate literal, chosen by a select input. Single-operand operations act on that second value alone. The result is available combinationally in the same cycle, so the surrounding core can steer it to whichever destination it needs.

On a clock edge with the write enable high, the status byte is updated. Four of its bits are the arithmetic flags: overflow, zero, digit carry and carry. The upper four bits hold two 2-bit mode fields. These tell the address generators of two indirect pointers whether to post-increment, post-decrement or hold their value after an access. The unit decodes those fields into per-pointer increment and decrement strobes.

The status byte can also be the destination of an operation. In that case the data and the flag logic compete for the low nibble, and rules decide which one wins.

Top module: `alu_status_unit`

## Requirements
- R1: While reset is asserted, and directly after it is released, the status byte reads 8'hF0. Both pointer-mode fields are 2'b11 and the four flag bits are 0.
- R2: Status bit 0 is C, bit 1 is DC, bit 2 is Z and bit 3 is OV. Bits 5:4 are the pointer-0 mode and bits 7:6 are the pointer-1 mode. A mode field decodes as 2'b00 post-decrement, 2'b01 post-increment and 2'b1x hold. The increment and decrement strobes of one pointer are never high together, and a mode field changes only when the status byte is the destination.
- R3: ADD (op 0), ADD-with-carry (op 1, which adds the stored C) and INC (op 14, which adds 1 to the second value) produce the 8-bit sum. C is the carry out of bit 7 and DC is the carry out of bit 3. OV is set when the signed result lies outside -128..+127. Z is set when the 8-bit result is zero.
- R4: SUB (op 2) gives the second value minus the working register, computed by adding the two's complement. DEC (op 15) gives the second value minus 1. For both, C and DC are 1 when no borrow occurs out of bit 7 and out of bit 3 respectively. OV and Z follow the rules of R3.
- R5: AND (op 3), OR (op 4) and XOR (op 5) combine the working register with the second value. COM (op 6) inverts the second value. These four update only Z, and OV, DC and C keep their values.
- R6: Rotate right through carry (op 7) returns {C, v[7:1]} and loads C with v[0]. Rotate left through carry (op 8) returns {v[6:0], C} and loads C with v[7]. Here v is the second value. Only C changes.
- R7: SWAP (op 9) exchanges the nibbles of the second value. BSET (op 10) and BCLR (op 11) set or clear the bit of the second value chosen by the 3-bit bit index. MOVE (op 12) returns the working register. None of these changes a flag.
- R8: When the status byte is the destination of an operation that affects any flag, bits 7:4 take the result data. Bits 3:0 ignore the data: each flag the operation affects takes its computed value, and the others keep their previous values.
- R9: CLR (op 13) returns 0 and affects only Z. With the status byte as destination it leaves 0000u1uu, where u is the old bit.
- R10: With the write enable low the status byte does not change, while the result output still shows the computed value.
- R11: When the status byte is the destination of an operation that affects no flag (ops 9 to 12), all eight bits take the result data.
- R12: The literal-select input picks the literal as the second value when high, and the file-register value when low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| wreg_i | input | 8 | Working register value |
| fval_i | input | 8 | File-register operand |
| lit_i | input | 8 | Immediate literal operand |
| use_lit_i | input | 1 | 1 selects the literal as the second value |
| bit_sel_i | input | 3 | Bit index for BSET and BCLR |
| dest_stat_i | input | 1 | 1 when the status byte is the destination |
| wr_en_i | input | 1 | Commit the operation's effect on the status byte |
| result_o | output | 8 | Computed result |
| status_o | output | 8 | Status byte |
| ptr0_mode_o | output | 2 | Pointer-0 mode field |
| ptr1_mode_o | output | 2 | Pointer-1 mode field |
| ptr_inc_o | output | 2 | Post-increment strobe per pointer |
| ptr_dec_o | output | 2 | Post-decrement strobe per pointer |

## Verification
The bench builds the unit with its default reset mode value 4'hF, which is the value R1 requires. That reset value leaves both pointers in hold. The decrement and increment encodings are reached only when status-destination writes load new mode fields, so the bench issues them early and repeats them in the random phase. With 8-bit data, the directed steps can reach every carry, borrow and signed-overflow boundary (0x7F+1, 0xFF+1, 0x80-1, 0x00-1, nibble wrap), and the random phase mixes all sixteen operations, both operand sources and both destinations.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW      = 8;
  localparam int NIB     = DW / 2;
  localparam int PTRS    = 2;
  localparam int MODE_W  = 2;
  localparam int FLAG_W  = 4;
  localparam int BIT_W   = $clog2(DW);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_AND  = 4'd3,
    OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_COM  = 4'd6,  OP_RRC  = 4'd7,
    OP_RLC  = 4'd8,  OP_SWAP = 4'd9,  OP_BSET = 4'd10, OP_BCLR = 4'd11,
    OP_MOVE = 4'd12, OP_CLR  = 4'd13, OP_INC  = 4'd14, OP_DEC  = 4'd15
  } op_e;

  // flag order matches the low nibble of the status byte
  typedef struct packed {
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  typedef struct packed {
    logic [DW-1:0] sum;
    logic          c;
    logic          dc;
    logic          ov;
  } add_t;

  // one adder serves add, subtract, increment and decrement
  function automatic add_t add_full(input logic [DW-1:0] x,
                                    input logic [DW-1:0] y,
                                    input logic          ci);
    add_t          r;
    logic [NIB:0]  lo;
    logic [DW:0]   full;
    lo     = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, ci};
    full   = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    r.sum  = full[DW-1:0];
    r.c    = full[DW];
    r.dc   = lo[NIB];
    r.ov   = (x[DW-1] == y[DW-1]) && (full[DW-1] != x[DW-1]);
    return r;
  endfunction

  // which flags an operation may change, in flags_t order {ov,z,dc,c}
  function automatic logic [FLAG_W-1:0] flag_mask(input op_e op);
    logic [FLAG_W-1:0] m;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB,
      OP_INC, OP_DEC:                m = 4'b1111;
      OP_AND, OP_OR, OP_XOR,
      OP_COM, OP_CLR:                m = 4'b0100;
      OP_RRC, OP_RLC:                m = 4'b0001;
      default:                       m = 4'b0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  op_e                op,
  input  logic [DW-1:0]      wreg,
  input  logic [DW-1:0]      src,
  input  logic [BIT_W-1:0]   bit_sel,
  input  logic               cin,
  output logic [DW-1:0]      result,
  output flags_t             flags,
  output logic [FLAG_W-1:0]  affected
);
  logic [DW-1:0] add_x;
  logic [DW-1:0] add_y;
  logic          add_ci;
  add_t          add_r;
  logic [DW-1:0] bit_mask;

  // adder operand steering
  always_comb begin
    add_x  = wreg;
    add_y  = src;
    add_ci = 1'b0;
    case (op)
      OP_ADDC: add_ci = cin;
      OP_SUB: begin
        add_x  = src;
        add_y  = ~wreg;
        add_ci = 1'b1;
      end
      OP_INC: begin
        add_x = src;
        add_y = {{(DW-1){1'b0}}, 1'b1};
      end
      OP_DEC: begin
        add_x = src;
        add_y = {DW{1'b1}};
      end
      default: ;
    endcase
  end

  assign add_r    = add_full(add_x, add_y, add_ci);
  assign bit_mask = {{(DW-1){1'b0}}, 1'b1} << bit_sel;
  assign affected = flag_mask(op);

  always_comb begin
    flags  = '0;
    result = '0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB,
      OP_INC, OP_DEC: begin
        result   = add_r.sum;
        flags.c  = add_r.c;
        flags.dc = add_r.dc;
        flags.ov = add_r.ov;
      end
      OP_AND:  result = wreg & src;
      OP_OR:   result = wreg | src;
      OP_XOR:  result = wreg ^ src;
      OP_COM:  result = ~src;
      OP_RRC: begin
        result  = {cin, src[DW-1:1]};
        flags.c = src[0];
      end
      OP_RLC: begin
        result  = {src[DW-2:0], cin};
        flags.c = src[DW-1];
      end
      OP_SWAP: result = {src[NIB-1:0], src[DW-1:NIB]};
      OP_BSET: result = src | bit_mask;
      OP_BCLR: result = src & ~bit_mask;
      OP_MOVE: result = wreg;
      OP_CLR:  result = '0;
      default: result = '0;
    endcase
    flags.z = (result == '0);
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
#(
  parameter logic [NIB-1:0] RST_MODES = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               dest_stat,
  input  logic [DW-1:0]      data,
  input  flags_t             flags,
  input  logic [FLAG_W-1:0]  affected,
  output logic [DW-1:0]      status,
  output logic               flag_guard
);
  logic [FLAG_W-1:0] flag_next;
  logic [FLAG_W-1:0] flag_new;
  logic [DW-1:0]     stat_next;

  assign flag_new = flags;

  // per-flag merge: computed value for affected flags, old value otherwise
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    assign flag_next[i] = affected[i] ? flag_new[i] : status[i];
  end

  // a flag-affecting operation aimed at the status byte loses the low nibble
  assign flag_guard = dest_stat && (|affected);

  always_comb begin
    stat_next = status;
    if (wr_en) begin
      if (dest_stat) begin
        stat_next[DW-1:NIB] = data[DW-1:NIB];
        stat_next[NIB-1:0]  = flag_guard ? flag_next : data[NIB-1:0];
      end else begin
        stat_next[NIB-1:0]  = flag_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= {RST_MODES, {NIB{1'b0}}};
    else        status <= stat_next;
  end
endmodule

// File: rtl/alu_ptr_decode.sv
module alu_ptr_decode
  import alu_pkg::*;
(
  input  logic [PTRS*MODE_W-1:0] modes,
  output logic [PTRS-1:0]        inc,
  output logic [PTRS-1:0]        dec
);
  for (genvar p = 0; p < PTRS; p++) begin : g_ptr
    logic [MODE_W-1:0] m;
    assign m      = modes[p*MODE_W +: MODE_W];
    assign inc[p] = (m == 2'b01);
    assign dec[p] = (m == 2'b00);
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter logic [3:0] RST_MODES = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op_i,
  input  logic [7:0]  wreg_i,
  input  logic [7:0]  fval_i,
  input  logic [7:0]  lit_i,
  input  logic        use_lit_i,
  input  logic [2:0]  bit_sel_i,
  input  logic        dest_stat_i,
  input  logic        wr_en_i,
  output logic [7:0]  result_o,
  output logic [7:0]  status_o,
  output logic [1:0]  ptr0_mode_o,
  output logic [1:0]  ptr1_mode_o,
  output logic [1:0]  ptr_inc_o,
  output logic [1:0]  ptr_dec_o
);
  op_e               op;
  logic [DW-1:0]     src_val;
  flags_t            calc_flags;
  logic [FLAG_W-1:0] flag_aff;
  logic              flag_guard;
  logic [DW-1:0]     status_q;

  assign op      = op_e'(op_i);
  assign src_val = use_lit_i ? lit_i : fval_i;

  alu_datapath u_dp (
    .op       (op),
    .wreg     (wreg_i),
    .src      (src_val),
    .bit_sel  (bit_sel_i),
    .cin      (status_q[0]),
    .result   (result_o),
    .flags    (calc_flags),
    .affected (flag_aff)
  );

  alu_status_reg #(.RST_MODES(RST_MODES)) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .dest_stat  (dest_stat_i),
    .data       (result_o),
    .flags      (calc_flags),
    .affected   (flag_aff),
    .status     (status_q),
    .flag_guard (flag_guard)
  );

  alu_ptr_decode u_pd (
    .modes (status_q[DW-1:NIB]),
    .inc   (ptr_inc_o),
    .dec   (ptr_dec_o)
  );

  assign status_o    = status_q;
  assign ptr0_mode_o = status_q[5:4];
  assign ptr1_mode_o = status_q[7:6];
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic       dest_stat_i,
  input logic       wr_en_i,
  input logic [7:0] result_o,
  input logic [7:0] status_o,
  input logic [1:0] ptr_inc_o,
  input logic [1:0] ptr_dec_o,
  input logic [3:0] flag_aff,
  input logic       flag_guard
);
  p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> status_o == 8'hF0);

  p_ptr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_inc_o[0], ptr_dec_o[0]}) && $onehot0({ptr_inc_o[1], ptr_dec_o[1]}));

  p_mode_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !dest_stat_i) |=> status_o[7:4] == $past(status_o[7:4]));

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !dest_stat_i && flag_aff[2]) |=> status_o[2] == ($past(result_o) == 8'h00));

  p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !dest_stat_i && op_i >= 4'd3 && op_i <= 4'd6)
    |=> {status_o[3], status_o[1:0]} == $past({status_o[3], status_o[1:0]}));

  p_noflag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !dest_stat_i && op_i >= 4'd9 && op_i <= 4'd12) |=> $stable(status_o));

  p_guard_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && flag_guard) |=> status_o[7:4] == $past(result_o[7:4]));

  p_clear_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && dest_stat_i && op_i == 4'd13)
    |=> status_o[7:4] == 4'h0 && status_o[2]
        && status_o[3] == $past(status_o[3]) && status_o[1:0] == $past(status_o[1:0]));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(status_o));

  p_raw_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && dest_stat_i && flag_aff == 4'h0) |=> status_o == $past(result_o));
endmodule

bind alu_status_unit alu_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .dest_stat_i (dest_stat_i),
  .wr_en_i     (wr_en_i),
  .result_o    (result_o),
  .status_o    (status_o),
  .ptr_inc_o   (ptr_inc_o),
  .ptr_dec_o   (ptr_dec_o),
  .flag_aff    (flag_aff),
  .flag_guard  (flag_guard)
);

// File: tb/sim_alu_status_unit.sv
`timescale 1ns/1ps
module sim_alu_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] wreg_i = '0, fval_i = '0, lit_i = '0;
  logic       use_lit_i = 1'b0;
  logic [2:0] bit_sel_i = '0;
  logic       dest_stat_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] result_o, status_o;
  logic [1:0] ptr0_mode_o, ptr1_mode_o, ptr_inc_o, ptr_dec_o;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_stat;   // reference status byte

  always #2.5 clk = ~clk;

  alu_status_unit u0 (.*);

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1, 14: return "R3";
      2, 15:    return "R4";
      3, 4, 5, 6: return "R5";
      7, 8:     return "R6";
      13:       return "R9";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: returns expected result and next status
  task automatic model(input int op, w, v, b, st, dest, wr,
                       output int res, output int nst);
    int c, dc, z, ov, sum, sv;
    bit ac, adc, az, aov;
    c = st & 1; dc = (st >> 1) & 1; z = (st >> 2) & 1; ov = (st >> 3) & 1;
    ac = 0; adc = 0; az = 0; aov = 0;
    res = 0;
    case (op)
      0, 1: begin
        sum = w + v + ((op == 1) ? c : 0);
        res = sum & 255;
        c = (sum > 255);
        dc = (((w & 15) + (v & 15) + ((op == 1) ? (st & 1) : 0)) > 15);
        sv = sgn(w) + sgn(v) + ((op == 1) ? (st & 1) : 0);
        ov = (sv > 127 || sv < -128);
        ac = 1; adc = 1; az = 1; aov = 1;
      end
      2: begin
        res = (v - w) & 255; c = (v >= w); dc = ((v & 15) >= (w & 15));
        sv = sgn(v) - sgn(w); ov = (sv > 127 || sv < -128);
        ac = 1; adc = 1; az = 1; aov = 1;
      end
      14: begin
        res = (v + 1) & 255; c = (v == 255); dc = ((v & 15) == 15); ov = (v == 127);
        ac = 1; adc = 1; az = 1; aov = 1;
      end
      15: begin
        res = (v - 1) & 255; c = (v != 0); dc = ((v & 15) != 0); ov = (v == 128);
        ac = 1; adc = 1; az = 1; aov = 1;
      end
      3: begin res = w & v; az = 1; end
      4: begin res = w | v; az = 1; end
      5: begin res = w ^ v; az = 1; end
      6: begin res = (~v) & 255; az = 1; end
      7: begin res = ((st & 1) << 7) | (v >> 1); c = v & 1; ac = 1; end
      8: begin res = ((v << 1) & 255) | (st & 1); c = (v >> 7) & 1; ac = 1; end
      9: res = ((v << 4) & 240) | (v >> 4);
      10: res = v | (1 << b);
      11: res = v & ~(1 << b) & 255;
      12: res = w;
      default: begin res = 0; az = 1; end
    endcase
    z = (res == 0);
    begin
      int lo;
      lo = ((aov ? ov : (st >> 3) & 1) << 3) | ((az ? z : (st >> 2) & 1) << 2)
         | ((adc ? dc : (st >> 1) & 1) << 1) | (ac ? c : st & 1);
      if (!wr) nst = st;
      else if (dest) nst = (ac | adc | az | aov) ? ((res & 240) | lo) : res;
      else nst = (st & 240) | lo;
    end
  endtask

  task automatic check_ptrs(string req);
    int m0, m1;
    m0 = (m_stat >> 4) & 3; m1 = (m_stat >> 6) & 3;
    chk(req, "ptr0_mode", ptr0_mode_o, m0);
    chk(req, "ptr1_mode", ptr1_mode_o, m1);
    chk(req, "ptr_inc", ptr_inc_o, {(m1 == 1), (m0 == 1)});
    chk(req, "ptr_dec", ptr_dec_o, {(m1 == 0), (m0 == 0)});
  endtask

  task automatic step(int op, int w, int f, int l, int ul, int b, int dest, int wr, string req);
    int v, eres, nst;
    @(negedge clk);
    op_i = op[3:0]; wreg_i = w[7:0]; fval_i = f[7:0]; lit_i = l[7:0];
    use_lit_i = ul[0]; bit_sel_i = b[2:0]; dest_stat_i = dest[0]; wr_en_i = wr[0];
    v = ul ? l : f;
    model(op, w, v, b, m_stat, dest, wr, eres, nst);
    #1;
    chk(req, "result", result_o, eres);
    @(posedge clk);
    m_stat = nst;
    #1;
    chk(req, "status", status_o, m_stat);
    check_ptrs("R2");
  endtask

  initial begin
    m_stat = 8'hF0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "status in reset", status_o, 8'hF0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", "status after release", status_o, 8'hF0);
    check_ptrs("R2");

    // mode fields: ptr1=00 decrement, ptr0=01 increment (R11, R2)
    step(12, 8'h1A, 0, 0, 0, 0, 1, 1, "R11");
    step(9, 0, 8'h0E, 0, 0, 0, 1, 1, "R11");   // swap -> E0: both hold modes
    step(10, 0, 8'h00, 0, 0, 4, 1, 1, "R11");  // bset bit4 -> 0x10
    step(11, 0, 8'hFF, 0, 0, 7, 1, 1, "R11");  // bclr bit7 -> 0x7F
    // R3 additions
    step(0, 8'h7F, 8'h01, 0, 0, 0, 0, 1, "R3");
    step(0, 8'hFF, 8'h01, 0, 0, 0, 0, 1, "R3");
    step(1, 8'h10, 8'h20, 0, 0, 0, 0, 1, "R3");
    step(0, 8'h80, 8'h80, 0, 0, 0, 0, 1, "R3");
    step(14, 0, 8'hFF, 0, 0, 0, 0, 1, "R3");
    step(14, 0, 8'h7F, 0, 0, 0, 0, 1, "R3");
    // R4 subtraction and decrement
    step(2, 8'h03, 8'h05, 0, 0, 0, 0, 1, "R4");
    step(2, 8'h05, 8'h03, 0, 0, 0, 0, 1, "R4");
    step(2, 8'h01, 8'h80, 0, 0, 0, 0, 1, "R4");
    step(2, 8'h01, 8'h10, 0, 0, 0, 0, 1, "R4");
    step(2, 8'h42, 8'h42, 0, 0, 0, 0, 1, "R4");
    step(15, 0, 8'h00, 0, 0, 0, 0, 1, "R4");
    step(15, 0, 8'h80, 0, 0, 0, 0, 1, "R4");
    // R5 logic with flags set beforehand
    step(0, 8'hFF, 8'h81, 0, 0, 0, 0, 1, "R3");
    step(3, 8'hF0, 8'h0F, 0, 0, 0, 0, 1, "R5");
    step(4, 8'h00, 8'h01, 0, 0, 0, 0, 1, "R5");
    step(5, 8'h5A, 8'h5A, 0, 0, 0, 0, 1, "R5");
    step(6, 0, 8'hFF, 0, 0, 0, 0, 1, "R5");
    // R6 rotates through carry
    step(7, 0, 8'h01, 0, 0, 0, 0, 1, "R6");
    step(7, 0, 8'h80, 0, 0, 0, 0, 1, "R6");
    step(8, 0, 8'h80, 0, 0, 0, 0, 1, "R6");
    step(8, 0, 8'h01, 0, 0, 0, 0, 1, "R6");
    // R7 no-flag ops keep flags
    step(9, 0, 8'h3C, 0, 0, 0, 0, 1, "R7");
    step(10, 0, 8'h00, 0, 0, 0, 0, 1, "R7");
    step(11, 0, 8'hFF, 0, 0, 3, 0, 1, "R7");
    step(12, 8'h00, 0, 0, 0, 0, 0, 1, "R7");
    // R10 write enable low
    step(0, 8'hFF, 8'h01, 0, 0, 0, 0, 0, "R10");
    step(13, 0, 0, 0, 0, 0, 1, 0, "R10");
    // R8 flag-affecting op into status
    step(0, 8'hF0, 8'h20, 0, 0, 0, 1, 1, "R8");
    step(2, 8'h01, 8'h6F, 0, 0, 0, 1, 1, "R8");
    step(3, 8'h5F, 8'hF5, 0, 0, 0, 1, 1, "R8");
    step(7, 0, 8'hA3, 0, 0, 0, 1, 1, "R8");
    // R9 clear into status
    step(0, 8'hFF, 8'h89, 0, 0, 0, 0, 1, "R3");
    step(13, 0, 0, 0, 0, 0, 1, 1, "R9");
    step(13, 0, 0, 0, 0, 0, 0, 1, "R9");
    // R12 operand source select
    step(0, 8'h01, 8'h10, 8'h20, 1, 0, 0, 1, "R12");
    step(0, 8'h01, 8'h10, 8'h20, 0, 0, 0, 1, "R12");
    step(9, 0, 8'hAB, 8'hCD, 1, 0, 0, 1, "R12");

    // mixed random phase
    for (int i = 0; i < 600; i++) begin
      int op, dest;
      op = $urandom_range(15);
      dest = ($urandom_range(7) == 0);
      step(op, $urandom_range(255), $urandom_range(255), $urandom_range(255),
           $urandom_range(1), $urandom_range(7), dest, ($urandom_range(9) != 0),
           dest ? "R8" : tag_of(op));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule